// File: doc/BRIEF.md
# Voice Phase Accumulator with Hard Sync

This block keeps the 24-bit running phase of one oscillator voice. Every clock it adds a stored 16-bit frequency word to the phase, wrapping modulo 2^24. It also reports, as single-cycle pulses, the moments when bit 23 and bit 19 of the phase turn from 0 to 1. The bit-23 pulse serves as the hard-sync source for a neighbouring voice. The bit-19 pulse clocks a noise generator that lives outside this block.

Software loads a control byte and a frequency word through two write strobes. The control byte holds a 4-bit waveform select, a test bit that parks the phase at zero, a ring-modulation enable and a sync enable. From two of those bits the block derives a 24-bit mask that tells the waveform stage whether to replace the phase MSB with the ring-modulation source.

When sync is enabled, the block watches the MSB-rise pulse of its source voice and forces its own phase to zero. There is one exception: the clear is withheld when the source voice is itself being resynced by its own source in that same cycle. A neighbour supplies that condition on `src_resync`.

The control decode is a two-state machine:
- `ST_RUN`: the phase advances.
- `ST_TEST`: the phase is held at zero.
- `TEST_ENTER` moves from `ST_RUN` to `ST_TEST` on a control write with the test bit set.
- `TEST_LEAVE` moves back on a control write with the test bit clear.
- Any other write leaves the state where it is.

Top module: `phase_acc_voice`

## Requirements
- R1: Control byte layout: bits 7..4 are the waveform select, with bit 5 as the sawtooth select. Bit 3 is test, bit 2 is ring-modulation enable and bit 1 is sync enable. Bit 0 is ignored. A write on `ctrl_we` takes effect at the next rising clock edge, and `wave_sel` shows bits 7..4 from then on.
- R2: `ring_mask` is 0x800000 when the stored control has bit 5 = 0 and bit 2 = 1. It is 0x000000 otherwise. Bits 22..0 are always 0.
- R3: In each cycle where the stored test bit is clear and no sync clear applies, `acc_out` becomes the old `acc_out` plus the stored frequency word, modulo 2^24.
- R4: At the first edge after the control register holds test = 1, `acc_out` becomes 0. It stays 0 at every edge while test remains set, whatever the frequency word is.
- R5: `msb_rise` is high for exactly the one cycle after an addition that takes `acc_out` bit 23 from 0 to 1. A clear never raises it.
- R6: `tap_rise` is high for the one cycle after an addition that takes `acc_out` bit 19 from 0 to 1. A clear never raises it.
- R7: When the stored sync enable is 1 and `src_msb_rise` is high (with `src_resync` low), `acc_out` becomes 0 at the next edge instead of adding. With sync enable 0, `src_msb_rise` has no effect.
- R8: When `src_resync` is high in the same cycle as `src_msb_rise`, the sync clear is withheld and the normal addition happens.
- R9: Reset (`rst_n` low at an edge) clears the frequency word, the control fields, the test state and both rise flags. It leaves `acc_out` unchanged.
- R10: A write on `freq_we` loads `freq_in` at the next edge. The new word is used from the following addition on.
- R11: Test has priority over sync: while test is set, `acc_out` is 0 and neither flag rises, even with a sync request present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| freq_we | input | 1 | Load strobe for the frequency word |
| freq_in | input | 16 | Frequency word to load |
| ctrl_we | input | 1 | Load strobe for the control byte |
| ctrl_in | input | 8 | Control byte to load |
| src_msb_rise | input | 1 | MSB-rise pulse of the sync source voice |
| src_resync | input | 1 | High when the source voice is itself being synced this cycle |
| acc_out | output | 24 | Current phase value |
| msb_rise | output | 1 | One-cycle pulse: bit 23 rose on the last addition |
| tap_rise | output | 1 | One-cycle pulse: bit 19 rose on the last addition |
| ring_mask | output | 24 | MSB substitution mask for ring modulation |
| wave_sel | output | 4 | Stored waveform select |

## Verification
A control or frequency write is visible at the first edge after its strobe:
- `ring_mask` and `wave_sel` change at that edge.
- A change of the test bit reaches `acc_out` one edge later, because the phase update reads the stored control.
- The rise flags and a sync clear show up at the same edge as the phase update that causes them.

The bench drives inputs and samples outputs on the falling edge, so each expected value is compared half a cycle after the edge that produces it. A cycle model in the bench applies the same rules from the requirements at every rising edge. Directed sequences compare against literal values, including pulse counts over a 300-cycle sweep at frequency 0xFFFF.

// File: rtl/pa_pkg.sv
package pa_pkg;

    localparam int ACC_W  = 24;
    localparam int FREQ_W = 16;
    localparam int CTRL_W = 8;
    localparam int TAP_POS = 19;

    // control byte field positions (the layout is fixed by the register map)
    localparam int CB_WAVE_LO = 4;
    localparam int CB_SAW     = 5;
    localparam int CB_TEST    = 3;
    localparam int CB_RING    = 2;
    localparam int CB_SYNC    = 1;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_TEST = 1'b1
    } ctrl_state_e;

    typedef struct packed {
        logic [3:0] wave;
        logic       ring;
        logic       sync;
    } ctrl_fields_t;

endpackage

// File: rtl/pa_ctrl_reg.sv
module pa_ctrl_reg
    import pa_pkg::*;
#(
    parameter int P_ACC_W  = ACC_W,
    parameter int P_FREQ_W = FREQ_W,
    parameter int P_CTRL_W = CTRL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_we,
    input  logic [P_CTRL_W-1:0] ctrl_in,
    input  logic                freq_we,
    input  logic [P_FREQ_W-1:0] freq_in,
    output logic [P_FREQ_W-1:0] freq_q,
    output logic                test_q,
    output logic                sync_q,
    output logic [3:0]          wave_q,
    output logic [P_ACC_W-1:0]  ring_mask
);

    ctrl_state_e  state_q;
    ctrl_state_e  state_nx;
    ctrl_fields_t fields_q;
    logic         unused_ctrl_bit;

    assign unused_ctrl_bit = ctrl_in[0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions: TEST_ENTER and TEST_LEAVE
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ctrl_we && ctrl_in[CB_TEST]) begin
                    state_nx = ST_TEST;
                end
            end
            ST_TEST: begin
                if (ctrl_we && !ctrl_in[CB_TEST]) begin
                    state_nx = ST_RUN;
                end
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // outputs of the machine
    always_comb begin
        test_q = 1'b0;
        unique case (state_q)
            ST_RUN:  test_q = 1'b0;
            ST_TEST: test_q = 1'b1;
            default: test_q = 1'b0;
        endcase
    end

    // remaining control fields and frequency word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= '0;
            freq_q   <= '0;
        end else begin
            if (ctrl_we) begin
                fields_q.wave <= ctrl_in[CB_WAVE_LO +: 4];
                fields_q.ring <= ctrl_in[CB_RING];
                fields_q.sync <= ctrl_in[CB_SYNC];
            end
            if (freq_we) begin
                freq_q <= freq_in;
            end
        end
    end

    assign sync_q = fields_q.sync;
    assign wave_q = fields_q.wave;

    // sawtooth select sits inside the waveform nibble
    localparam int SAW_IN_WAVE = CB_SAW - CB_WAVE_LO;

    assign ring_mask = {fields_q.ring & ~fields_q.wave[SAW_IN_WAVE],
                        {(P_ACC_W-1){1'b0}}};

endmodule

// File: rtl/pa_sync.sv
module pa_sync (
    input  logic sync_en,
    input  logic src_msb_rise,
    input  logic src_resync,
    output logic sync_clr
);

    // a source that is being reset itself in the same cycle does not sync us
    assign sync_clr = sync_en & src_msb_rise & ~src_resync;

endmodule

// File: rtl/pa_accum.sv
module pa_accum
    import pa_pkg::*;
#(
    parameter int P_ACC_W  = ACC_W,
    parameter int P_FREQ_W = FREQ_W,
    parameter int P_TAP    = TAP_POS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold_zero,
    input  logic                sync_clr,
    input  logic [P_FREQ_W-1:0] freq,
    output logic [P_ACC_W-1:0]  acc_q,
    output logic                msb_rise,
    output logic                tap_rise
);

    localparam int N_WATCH = 2;
    localparam int PAD_W   = P_ACC_W - P_FREQ_W;

    logic [P_ACC_W-1:0] acc_nx;
    logic               clr;
    logic [N_WATCH-1:0] rise_q;

    assign clr = hold_zero | sync_clr;

    always_comb begin
        if (clr) begin
            acc_nx = '0;
        end else begin
            acc_nx = acc_q + {{PAD_W{1'b0}}, freq};
        end
    end

    // the phase survives reset; only test or sync clears it
    always_ff @(posedge clk) begin
        if (rst_n) begin
            acc_q <= acc_nx;
        end
    end

    // one edge detector per watched phase bit
    for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
        localparam int POS = (g == 0) ? (P_ACC_W - 1) : P_TAP;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rise_q[g] <= 1'b0;
            end else begin
                rise_q[g] <= ~clr & ~acc_q[POS] & acc_nx[POS];
            end
        end
    end

    assign msb_rise = rise_q[0];
    assign tap_rise = rise_q[1];

endmodule

// File: rtl/phase_acc_voice.sv
module phase_acc_voice
    import pa_pkg::*;
#(
    parameter int P_ACC_W  = ACC_W,
    parameter int P_FREQ_W = FREQ_W,
    parameter int P_CTRL_W = CTRL_W,
    parameter int P_TAP    = TAP_POS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                freq_we,
    input  logic [P_FREQ_W-1:0] freq_in,
    input  logic                ctrl_we,
    input  logic [P_CTRL_W-1:0] ctrl_in,
    input  logic                src_msb_rise,
    input  logic                src_resync,
    output logic [P_ACC_W-1:0]  acc_out,
    output logic                msb_rise,
    output logic                tap_rise,
    output logic [P_ACC_W-1:0]  ring_mask,
    output logic [3:0]          wave_sel
);

    logic [P_FREQ_W-1:0] freq_q;
    logic                test_q;
    logic                sync_q;
    logic                sync_clr;

    pa_ctrl_reg #(
        .P_ACC_W  (P_ACC_W),
        .P_FREQ_W (P_FREQ_W),
        .P_CTRL_W (P_CTRL_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .ctrl_in   (ctrl_in),
        .freq_we   (freq_we),
        .freq_in   (freq_in),
        .freq_q    (freq_q),
        .test_q    (test_q),
        .sync_q    (sync_q),
        .wave_q    (wave_sel),
        .ring_mask (ring_mask)
    );

    pa_sync u_sync (
        .sync_en      (sync_q),
        .src_msb_rise (src_msb_rise),
        .src_resync   (src_resync),
        .sync_clr     (sync_clr)
    );

    pa_accum #(
        .P_ACC_W  (P_ACC_W),
        .P_FREQ_W (P_FREQ_W),
        .P_TAP    (P_TAP)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (test_q),
        .sync_clr  (sync_clr),
        .freq      (freq_q),
        .acc_q     (acc_out),
        .msb_rise  (msb_rise),
        .tap_rise  (tap_rise)
    );

endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
    parameter int P_ACC_W  = 24,
    parameter int P_FREQ_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                test_q,
    input logic                sync_q,
    input logic                src_msb_rise,
    input logic                src_resync,
    input logic [P_FREQ_W-1:0] freq_q,
    input logic [P_ACC_W-1:0]  acc_out,
    input logic                msb_rise,
    input logic [P_ACC_W-1:0]  ring_mask
);

    logic primed;

    always_ff @(posedge clk) begin
        primed <= 1'b1;
    end

    AST_TEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        test_q |=> (acc_out == '0)); // R4

    AST_ADD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_q && !(sync_q && src_msb_rise && !src_resync))
        |=> (acc_out == P_ACC_W'($past(acc_out) + P_ACC_W'($past(freq_q))))); // R3

    AST_MSB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        msb_rise |-> acc_out[P_ACC_W-1]); // R5

    AST_MSB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        msb_rise |=> !msb_rise); // R5

    AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q && src_msb_rise && !src_resync) |=> (acc_out == '0)); // R7

    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ring_mask) <= 1) && (ring_mask[P_ACC_W-2:0] == '0)); // R2

    AST_RESET_KEEP: assert property (@(posedge clk)
        (primed && !rst_n) |=> $stable(acc_out)); // R9

endmodule

bind phase_acc_voice pa_checker #(
    .P_ACC_W  (P_ACC_W),
    .P_FREQ_W (P_FREQ_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .test_q       (test_q),
    .sync_q       (sync_q),
    .src_msb_rise (src_msb_rise),
    .src_resync   (src_resync),
    .freq_q       (freq_q),
    .acc_out      (acc_out),
    .msb_rise     (msb_rise),
    .ring_mask    (ring_mask)
);

// File: tb/phase_acc_voice_test.sv
`timescale 1ns/1ps
module phase_acc_voice_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freq_we = 1'b0;
    logic [15:0] freq_in = '0;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_in = '0;
    logic        src_msb_rise = 1'b0;
    logic        src_resync = 1'b0;
    logic [23:0] acc_out;
    logic        msb_rise;
    logic        tap_rise;
    logic [23:0] ring_mask;
    logic [3:0]  wave_sel;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    phase_acc_voice uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .freq_we      (freq_we),
        .freq_in      (freq_in),
        .ctrl_we      (ctrl_we),
        .ctrl_in      (ctrl_in),
        .src_msb_rise (src_msb_rise),
        .src_resync   (src_resync),
        .acc_out      (acc_out),
        .msb_rise     (msb_rise),
        .tap_rise     (tap_rise),
        .ring_mask    (ring_mask),
        .wave_sel     (wave_sel)
    );

    // cycle model built from the requirements
    logic [23:0] m_acc = '0;
    logic [15:0] m_freq = '0;
    logic        m_test = 1'b0, m_ring = 1'b0, m_saw = 1'b0, m_sync = 1'b0;
    logic        m_msb = 1'b0, m_tap = 1'b0, m_valid = 1'b0;

    function automatic logic [23:0] exp_mask(logic ring, logic saw);
        return (ring && !saw) ? 24'h800000 : 24'h000000;
    endfunction

    always @(posedge clk) begin
        logic        clr;
        logic [23:0] nacc;
        if (!rst_n) begin
            m_freq <= '0;
            m_test <= 1'b0; m_ring <= 1'b0; m_saw <= 1'b0; m_sync <= 1'b0;
            m_msb  <= 1'b0; m_tap <= 1'b0;
        end else begin
            clr  = m_test | (m_sync & src_msb_rise & ~src_resync);
            nacc = clr ? 24'h0 : 24'(m_acc + {8'h00, m_freq});
            m_acc <= nacc;
            m_msb <= ~clr & ~m_acc[23] & nacc[23];
            m_tap <= ~clr & ~m_acc[19] & nacc[19];
            if (m_test) m_valid <= 1'b1;
            if (freq_we) m_freq <= freq_in;
            if (ctrl_we) begin
                m_test <= ctrl_in[3];
                m_ring <= ctrl_in[2];
                m_saw  <= ctrl_in[5];
                m_sync <= ctrl_in[1];
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        check("R2 ring_mask model", 32'(ring_mask), 32'(exp_mask(m_ring, m_saw)));
        if (m_valid) begin
            check("R3 acc model", 32'(acc_out), 32'(m_acc));
            check("R5 msb_rise model", 32'(msb_rise), 32'(m_msb));
            check("R6 tap_rise model", 32'(tap_rise), 32'(m_tap));
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare_model();
    endtask

    task automatic wr_ctrl(logic [7:0] v);
        ctrl_we = 1'b1; ctrl_in = v;
        tick();
        ctrl_we = 1'b0;
    endtask

    task automatic wr_freq(logic [15:0] v);
        freq_we = 1'b1; freq_in = v;
        tick();
        freq_we = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] held;
        int n_msb;
        int n_tap;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        check("R9 reset msb_rise", 32'(msb_rise), 0);
        check("R9 reset tap_rise", 32'(tap_rise), 0);
        check("R9 reset ring_mask", 32'(ring_mask), 0);
        check("R1 reset wave_sel", 32'(wave_sel), 0);
        rst_n = 1'b1;

        // R4: test parks the phase at zero
        wr_ctrl(8'h08);
        tick();
        check("R4 acc cleared by test", 32'(acc_out), 0);
        wr_freq(16'h0100);
        tick();
        check("R4 acc held at zero with freq set", 32'(acc_out), 0);

        // R10 / R3: release test, four additions of 0x100
        wr_ctrl(8'h00);
        check("R4 acc zero at release edge", 32'(acc_out), 0);
        repeat (4) tick();
        check("R10 R3 acc after four adds", 32'(acc_out), 32'h400);

        // R9: reset keeps phase, clears frequency
        rst_n = 1'b0;
        tick(); tick();
        check("R9 acc kept through reset", 32'(acc_out), 32'h400);
        rst_n = 1'b1;
        repeat (3) tick();
        check("R9 freq cleared by reset", 32'(acc_out), 32'h400);

        // R2 / R1: mask decode
        wr_ctrl(8'h04);
        check("R2 ring without saw", 32'(ring_mask), 32'h800000);
        wr_ctrl(8'h24);
        check("R2 ring with saw", 32'(ring_mask), 0);
        wr_ctrl(8'h14);
        check("R1 triangle plus ring", 32'(ring_mask), 32'h800000);
        check("R1 wave_sel field", 32'(wave_sel), 32'h1);

        // R7: sync clear
        wr_ctrl(8'h02);
        src_msb_rise = 1'b1;
        tick();
        src_msb_rise = 1'b0;
        check("R7 sync clears acc", 32'(acc_out), 0);
        wr_freq(16'h0010);
        repeat (3) tick();
        wr_freq(16'h0000);
        check("R3 acc after small adds", 32'(acc_out), 32'h40);

        // R8: exception
        src_msb_rise = 1'b1; src_resync = 1'b1;
        tick();
        src_msb_rise = 1'b0; src_resync = 1'b0;
        check("R8 resyncing source does not clear", 32'(acc_out), 32'h40);

        // R7: sync disabled ignores the source
        wr_ctrl(8'h00);
        src_msb_rise = 1'b1;
        tick();
        src_msb_rise = 1'b0;
        check("R7 sync off ignores source", 32'(acc_out), 32'h40);

        // R11: test over sync
        wr_ctrl(8'h0A);
        src_msb_rise = 1'b1;
        tick();
        check("R11 test wins acc", 32'(acc_out), 0);
        check("R11 test wins msb", 32'(msb_rise), 0);
        src_msb_rise = 1'b0;

        // R5 / R6: sweep of 300 additions at 0xFFFF from zero
        wr_freq(16'hFFFF);
        wr_ctrl(8'h00);
        n_msb = 0; n_tap = 0;
        for (int k = 0; k < 300; k++) begin
            tick();
            if (msb_rise) n_msb++;
            if (tap_rise) n_tap++;
        end
        check("R5 msb_rise count", 32'(n_msb), 1);
        check("R6 tap_rise count", 32'(n_tap), 19);
        check("R3 acc after sweep", 32'(acc_out), 32'(24'(300 * 65535)));

        // constrained random phase
        for (int i = 0; i < 3000; i++) begin
            freq_we = ($urandom % 4) == 0;
            freq_in = 16'($urandom);
            ctrl_we = ($urandom % 8) == 0;
            ctrl_in = 8'($urandom) & (($urandom % 16) == 0 ? 8'hFF : 8'hF7);
            src_msb_rise = ($urandom % 5) == 0;
            src_resync   = ($urandom % 3) == 0;
            tick();
        end
        freq_we = 1'b0; ctrl_we = 1'b0;
        src_msb_rise = 1'b0; src_resync = 1'b0;

        // R9: reset mid-run with model comparison
        held = acc_out;
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        check("R9 acc kept by late reset", 32'(acc_out), 32'(held));
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule